// File: doc/BRIEF.md
# UART Transmitter with FIFO and Holding-Empty Interrupt

This block is the sending half of a 16550-style serial port. Software writes characters through a holding-register strobe into a 16-deep queue. A shift stage takes characters out of the queue one at a time and sends each as an 8N1 frame, one bit per baud tick. The line idles high.

The block reports `thr_empty`, which is high only when the whole queue is empty. One free slot is not enough to set it. Software that sees the flag may therefore write a full queue's worth of bytes at once.

An interrupt request follows the empty condition, with a start-up rule:
- If the queue has held two or more characters at the same time since the last empty event, the request is raised as soon as the queue drains.
- Otherwise, the request waits nine bit times (one character minus its stop bit) after the empty event. This gives software time to fill the queue without handling an interrupt.

The request is cleared by a holding-register write, or by an identification read while the request is pending.

Top module: `uart_tx_thre`

## Requirements
- R1: After reset `txd` is 1, `thr_empty` is 1, `thre_irq` is 0, `ovf_pulse` is 0 and `irq_id` is 4'b0001.
- R2: Each character goes out as a start bit (0), then 8 data bits LSB first, then a stop bit (1). Each bit changes on a baud tick. Characters leave in write order.
- R3: The queue holds 16 characters. A character already moved into the shift stage does not occupy a slot.
- R4: `thr_empty` is 1 only when the queue holds no character. It stays 0 while at least one character is queued.
- R5: `thr_empty` goes low on the clock edge that accepts a write.
- R6: `thr_empty` goes high on the clock edge that moves the last queued character into the shift stage, while that character is still being sent.
- R7: `irq_id` reads 4'b0010 (bits [3:1] = 001, bit 0 = 0 meaning a request is pending) while `thre_irq` is high. Otherwise it reads 4'b0001.
- R8: If the queue has not held two characters at once since the last empty event, the request is raised only after 9 baud ticks counted from that event. It is not raised within 8 ticks.
- R9: If the queue held two or more characters at once, the request is raised on the clock edge after `thr_empty` rises.
- R10: A pending request is cleared by a holding-register write. It is also cleared by `iir_rd` while `thre_irq` is high. After a read clears it, the request stays low until the next empty event.
- R11: `thre_irq` is 0 while `thre_ie` is 0. A pending request is kept, and it shows as soon as `thre_ie` is set. With `thre_ie` at 0, `iir_rd` does not clear the pending request.
- R12: A write to a full queue is dropped, and `ovf_pulse` is high for the one cycle after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_wr | input | 1 | Holding-register write strobe |
| thr_data | input | 8 | Character to write |
| iir_rd | input | 1 | Interrupt identification read strobe |
| thre_ie | input | 1 | Enable for the holding-empty interrupt |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| txd | output | 1 | Serial output, idles high |
| thr_empty | output | 1 | Whole transmit queue empty |
| thre_irq | output | 1 | Holding-empty interrupt request |
| irq_id | output | 4 | Interrupt identification code |
| ovf_pulse | output | 1 | Write-to-full indication |

## Verification
The bench drives the interrupt logic with three write patterns, and each one separates the two start-up paths:
- A lone write never puts two characters in the queue at once, so it must produce the nine-tick delayed request.
- A three-byte burst does put two characters in the queue at once, so it must produce the immediate request.
- An eighteen-byte burst overruns the queue. It shows whether capacity is counted with or without the shift stage, and which write is dropped.

A scoreboard decodes every frame on `txd` and compares it with the bytes the bench accepted. The data values used (all zeros, all ones, alternating bits, counting values) expose bit-order and framing errors.

// File: rtl/uart_tx_thre.sv
module uart_tx_thre #(
  parameter int DEPTH    = 16,
  parameter int DW       = 8,
  parameter int DLY_BITS = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          thr_wr,
  input  logic [DW-1:0] thr_data,
  input  logic          iir_rd,
  input  logic          thre_ie,
  input  logic          baud_tick,
  output logic          txd,
  output logic          thr_empty,
  output logic          thre_irq,
  output logic [3:0]    irq_id,
  output logic          ovf_pulse
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int FW  = DW + 2;
  localparam int BCW = $clog2(FW + 1);
  localparam int DCW = $clog2(DLY_BITS + 1);

  logic [DW-1:0]  mem [DEPTH];
  logic [AW-1:0]  wp, rp;
  logic [CW-1:0]  cnt;
  logic [FW-1:0]  frame;
  logic [BCW-1:0] bits_left;
  logic           busy;
  logic           empty_d1, held2, dly_on, pend;
  logic [DCW-1:0] dly_cnt;

  wire full  = (cnt == CW'(DEPTH));
  wire push  = thr_wr & ~full;
  wire pop   = ~busy & (cnt != '0);
  wire rise  = thr_empty & ~empty_d1;
  wire clr   = thr_wr | (iir_rd & thre_irq);

  assign thr_empty = (cnt == '0);
  assign txd       = busy ? frame[0] : 1'b1;
  assign thre_irq  = pend & thre_ie;
  assign irq_id    = thre_irq ? 4'b0010 : 4'b0001;

  always_ff @(posedge clk)
    if (push) mem[wp] <= thr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp        <= '0;
      rp        <= '0;
      cnt       <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= thr_wr & full;
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      frame     <= '1;
      bits_left <= '0;
    end else if (pop) begin
      busy      <= 1'b1;
      frame     <= {1'b1, mem[rp], 1'b0};
      bits_left <= BCW'(FW);
    end else if (busy && baud_tick) begin
      if (bits_left == BCW'(1)) begin
        busy <= 1'b0;
      end else begin
        frame     <= {1'b1, frame[FW-1:1]};
        bits_left <= bits_left - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      empty_d1 <= 1'b1;
      held2    <= 1'b0;
      dly_on   <= 1'b1;
      dly_cnt  <= '0;
      pend     <= 1'b0;
    end else begin
      empty_d1 <= thr_empty;
      if (rise)                 held2 <= 1'b0;
      else if (cnt >= CW'(2))   held2 <= 1'b1;

      if (!thr_empty) begin
        dly_on <= 1'b0;
      end else if (rise && !held2) begin
        dly_on  <= 1'b1;
        dly_cnt <= '0;
      end else if (dly_on && baud_tick) begin
        if (dly_cnt == DCW'(DLY_BITS - 1)) dly_on <= 1'b0;
        dly_cnt <= dly_cnt + 1'b1;
      end

      if (clr)
        pend <= 1'b0;
      else if (rise && held2)
        pend <= 1'b1;
      else if (thr_empty && dly_on && !rise && baud_tick &&
               dly_cnt == DCW'(DLY_BITS - 1))
        pend <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_thre_chk.sv
module uart_tx_thre_chk (
  input logic clk,
  input logic rst_n,
  input logic thr_wr,
  input logic iir_rd,
  input logic thr_empty,
  input logic thre_irq,
  input logic ovf_pulse
);
  assert_wr_clears_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !thr_empty);
  assert_irq_only_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    thre_irq |-> thr_empty);
  assert_ovf_after_wr_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> $past(thr_wr));
  assert_wr_clears_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !thre_irq);
  assert_rd_clears_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && thre_irq) |=> !thre_irq);
endmodule

bind uart_tx_thre uart_tx_thre_chk u_chk (
  .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .iir_rd(iir_rd),
  .thr_empty(thr_empty), .thre_irq(thre_irq), .ovf_pulse(ovf_pulse)
);

// File: tb/tb_uart_tx_thre.sv
module tb_uart_tx_thre;
  logic clk = 0, rst_n = 0, thr_wr = 0, iir_rd = 0, thre_ie = 0, baud_tick = 0;
  logic [7:0] thr_data = 0;
  logic txd, thr_empty, thre_irq, ovf_pulse;
  logic [3:0] irq_id;
  int total = 0, bad = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  uart_tx_thre dut (
    .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .thr_data(thr_data),
    .iir_rd(iir_rd), .thre_ie(thre_ie), .baud_tick(baud_tick),
    .txd(txd), .thr_empty(thr_empty), .thre_irq(thre_irq),
    .irq_id(irq_id), .ovf_pulse(ovf_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  initial begin
    forever begin
      repeat (7) @(negedge clk);
      baud_tick = 1;
      @(negedge clk);
      baud_tick = 0;
    end
  end

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      while (1) begin
        @(negedge clk);
        if (baud_tick) break;
      end
    end
  endtask

  // scoreboard monitor: R2 frame decode
  initial begin
    logic [7:0] got;
    forever begin
      @(negedge clk);
      if (rst_n && txd == 0) begin
        for (int i = 0; i < 8; i++) begin
          wait_ticks(1);
          @(negedge clk);
          got[i] = txd;
        end
        wait_ticks(1);
        @(negedge clk);
        chk(txd == 1, "R2 stop bit", txd, 1);
        if (exp_q.size() == 0) begin
          chk(0, "R2 unexpected byte", got, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(got == e, "R2 data", got, e);
        end
      end
    end
  end

  // one write; wr stays high after return so bursts run back to back
  task automatic put(input logic [7:0] d, input bit accepted);
    thr_wr = 1;
    thr_data = d;
    if (accepted) exp_q.push_back(d);
    @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    wait_ticks(2);
  endtask

  task automatic rd_pulse();
    iir_rd = 1;
    @(negedge clk);
    iir_rd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(txd == 1, "R1 txd", txd, 1);
    chk(thr_empty == 1, "R1 empty", thr_empty, 1);
    chk(thre_irq == 0, "R1 irq", thre_irq, 0);
    chk(ovf_pulse == 0, "R1 ovf", ovf_pulse, 0);
    chk(irq_id == 4'b0001, "R1 id", irq_id, 4'b0001);

    // R5/R6 single write, interrupt disabled
    put(8'hA5, 1); thr_wr = 0;
    chk(thr_empty == 0, "R5 empty low after write", thr_empty, 0);
    @(negedge clk);
    chk(thr_empty == 1, "R6 empty high after load", thr_empty, 1);
    chk(txd == 0, "R6 start bit in progress", txd, 0);
    drain();

    // R11 gating: pending kept while disabled, read does not clear
    wait_ticks(12);
    chk(thre_irq == 0, "R11 gated", thre_irq, 0);
    chk(irq_id == 4'b0001, "R7 id idle", irq_id, 4'b0001);
    rd_pulse();
    thre_ie = 1;
    @(negedge clk);
    chk(thre_irq == 1, "R11 pending shows", thre_irq, 1);
    chk(irq_id == 4'b0010, "R7 id pending", irq_id, 4'b0010);
    rd_pulse();
    chk(thre_irq == 0, "R10 read clears", thre_irq, 0);
    wait_ticks(12);
    chk(thre_irq == 0, "R10 stays clear", thre_irq, 0);

    // R8 delayed request after lone write
    put(8'h00, 1); thr_wr = 0;
    chk(thre_irq == 0, "R10 write clears", thre_irq, 0);
    @(negedge clk);
    chk(thr_empty == 1, "R6 empty again", thr_empty, 1);
    wait_ticks(8);
    chk(thre_irq == 0, "R8 no early irq", thre_irq, 0);
    wait_ticks(2);
    @(negedge clk);
    chk(thre_irq == 1, "R8 delayed irq", thre_irq, 1);
    drain();

    // R9 immediate request after burst of three
    put(8'hFF, 1); put(8'h3C, 1); put(8'h81, 1); thr_wr = 0;
    chk(thre_irq == 0, "R10 cleared by burst", thre_irq, 0);
    chk(thr_empty == 0, "R4 queue not empty", thr_empty, 0);
    while (!thr_empty) @(negedge clk);
    chk(thre_irq == 0, "R9 not before edge", thre_irq, 0);
    @(negedge clk);
    chk(thre_irq == 1, "R9 immediate irq", thre_irq, 1);
    drain();

    // R3/R12 overrun: 18 back-to-back writes, last dropped
    thre_ie = 0;
    for (int k = 0; k < 17; k++) begin
      put(8'(k * 13 + 1), 1);
      chk(ovf_pulse == 0, "R12 no ovf", ovf_pulse, 0);
    end
    put(8'hEE, 0); thr_wr = 0;
    chk(ovf_pulse == 1, "R12 ovf pulse", ovf_pulse, 1);
    @(negedge clk);
    chk(ovf_pulse == 0, "R12 pulse one cycle", ovf_pulse, 0);
    chk(thr_empty == 0, "R3 queue full", thr_empty, 0);
    drain();
    wait_ticks(12);
    chk(exp_q.size() == 0, "R3 all accepted sent", exp_q.size(), 0);
    chk(txd == 1, "R2 line idles high", txd, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule